// File: doc/BRIEF.md
# Addressed Three-Wire Serial Control Port

This block is the slave end of a three-wire host link: a chip-enable line, a serial clock and a data-in line, plus a data-out line that can only pull low. While chip enable is low the host clocks in an 8-bit address. Raising chip enable starts a transfer whose kind depends on that address. Three write addresses each lead to 24 data bits that load one of three 24-bit control latches. One read address makes the port shift out a 24-bit status word, one bit per host clock pulse.

All three host lines are oversampled by the fast system clock. Each passes through a two-flop synchronizer, and edges are found in the system clock domain. Written data sits in a staging register and reaches a latch only when chip enable falls, and only if the transfer was complete. The status word is taken from the parallel inputs at the moment read mode starts, so the host reads a consistent snapshot however slowly it clocks.

Top module: `ser_ctl_port`

## Requirements
- R1: The address is the last 8 bits clocked in while chip enable is low, in the order B0, B1, B2, B3, A0, A1, A2, A3. As the byte {B3,B2,B1,B0,A3,A2,A1,A0}, code 0x82 selects `latch_a`, 0x92 selects `latch_b`, 0xB2 selects `latch_c` and 0xA2 selects the status read.
- R2: A write transfer loads only the latch its address selects. The other two latches keep their values.
- R3: Data bits are sampled on serial clock rising edges while chip enable is high. A latch changes only after chip enable falls, never during the transfer.
- R4: A write transfer with fewer than 24 data bits leaves all latches unchanged.
- R5: Bit i of the loaded latch is the i-th data bit received, counting from 0. Bits after the 24th are ignored.
- R6: A transfer under an address that matches none of the four codes changes no latch and leaves `do_lo` at 0.
- R7: In read mode, `do_lo` is 1 exactly when the current status bit is 0. The first bit is shown as soon as read mode starts, and each falling serial clock edge moves to the next bit. The word is, first bit to last: `st_port[1]`, `st_port[0]`, `st_unlock`, `st_count` from MSB to LSB, `st_src`.
- R8: The status word is captured when read mode starts. Changes on the status inputs later in the same transfer do not affect the bits shifted out.
- R9: After all 24 status bits, further clock pulses leave `do_lo` at 0. A read cut short by chip enable falling releases `do_lo`, and the next read starts again from the first bit.
- R10: `do_lo` is 0 whenever the port is not in read mode: while chip enable is low, and while chip enable is high in a write or ignored transfer.
- R11: After reset all latches are zero and `do_lo` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_in | input | 1 | Host chip enable (asynchronous) |
| sclk_in | input | 1 | Host serial clock (asynchronous) |
| di_in | input | 1 | Host serial data in (asynchronous) |
| do_lo | output | 1 | Data-out drive enable; 1 pulls the line low |
| latch_a | output | 24 | Control latch for write code 0x82 |
| latch_b | output | 24 | Control latch for write code 0x92 |
| latch_c | output | 24 | Control latch for write code 0xB2 |
| st_port | input | 2 | Port status bits, captured at read start |
| st_unlock | input | 1 | Unlock flag, captured at read start |
| st_count | input | 20 | Count value, captured at read start |
| st_src | input | 1 | Selected-source bit, captured at read start |

## Verification
The bench sends a write to every one of the 256 address codes except the read code, with data unique to each code. A design that swapped address nibbles, reversed bit order, or decoded too loosely would load the wrong latch or load one for a stray code. Truncated and overlong transfers check that a port committing on a bit count, rather than on chip enable falling, or one taking the last 24 bits instead of the first, is caught. Reads compare every one of the 24 bits against the word computed in the bench, with the status inputs changed in the middle of the read. A read is also cut short early to show that a port which samples status late, shifts on the wrong edge, or does not restart its read pointer gives the wrong bits.

// File: rtl/ser_ctl_port.sv
module ser_ctl_port #(
  parameter int          DW    = 24,
  parameter int          CW    = 20,
  parameter int          PW    = 2,
  parameter logic [7:0]  CODE_A  = 8'h82,
  parameter logic [7:0]  CODE_B  = 8'h92,
  parameter logic [7:0]  CODE_C  = 8'hB2,
  parameter logic [7:0]  CODE_RD = 8'hA2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_in,
  input  logic          sclk_in,
  input  logic          di_in,
  output logic          do_lo,
  output logic [DW-1:0] latch_a,
  output logic [DW-1:0] latch_b,
  output logic [DW-1:0] latch_c,
  input  logic [PW-1:0] st_port,
  input  logic          st_unlock,
  input  logic [CW-1:0] st_count,
  input  logic          st_src
);
  localparam int RW = PW + CW + 2;
  localparam int BW = $clog2(DW + 1);

  typedef enum logic [2:0] {M_ADDR, M_WA, M_WB, M_WC, M_RD, M_IGN} mode_t;

  logic [2:0]    ce_q, ck_q;
  logic [1:0]    di_q;
  logic [7:0]    addr_sr;
  logic [DW-1:0] wr_sr;
  logic [RW-1:0] rd_sr;
  logic [BW-1:0] cnt;
  mode_t         mode;

  wire ce_rise  = ce_q[1] & ~ce_q[2];
  wire ce_fall  = ~ce_q[1] & ce_q[2];
  wire sck_rise = ck_q[1] & ~ck_q[2];
  wire sck_fall = ~ck_q[1] & ck_q[2];
  wire di_s     = di_q[1];
  wire is_wr    = (mode == M_WA) || (mode == M_WB) || (mode == M_WC);
  wire full     = (cnt == BW'(DW));

  wire [7:0] code = {addr_sr[4], addr_sr[5], addr_sr[6], addr_sr[7],
                     addr_sr[0], addr_sr[1], addr_sr[2], addr_sr[3]};

  assign do_lo = (mode == M_RD) & ~rd_sr[RW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q <= '0;
      ck_q <= '0;
      di_q <= '0;
    end else begin
      ce_q <= {ce_q[1:0], ce_in};
      ck_q <= {ck_q[1:0], sclk_in};
      di_q <= {di_q[0], di_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode    <= M_ADDR;
      addr_sr <= '0;
      wr_sr   <= '0;
      rd_sr   <= '1;
      cnt     <= '0;
      latch_a <= '0;
      latch_b <= '0;
      latch_c <= '0;
    end else if (ce_rise) begin
      cnt <= '0;
      if (code == CODE_A)       mode <= M_WA;
      else if (code == CODE_B)  mode <= M_WB;
      else if (code == CODE_C)  mode <= M_WC;
      else if (code == CODE_RD) begin
        mode  <= M_RD;
        rd_sr <= {st_port, st_unlock, st_count, st_src};
      end else                  mode <= M_IGN;
    end else if (ce_fall) begin
      if (full) begin
        if (mode == M_WA) latch_a <= wr_sr;
        if (mode == M_WB) latch_b <= wr_sr;
        if (mode == M_WC) latch_c <= wr_sr;
      end
      mode    <= M_ADDR;
      addr_sr <= '0;
    end else if (sck_rise) begin
      if (mode == M_ADDR) addr_sr <= {addr_sr[6:0], di_s};
      else if (is_wr && !full) begin
        wr_sr[cnt] <= di_s;
        cnt        <= cnt + 1'b1;
      end
    end else if (sck_fall && mode == M_RD) begin
      rd_sr <= {rd_sr[RW-2:0], 1'b1};
    end
  end
endmodule

// File: rtl/ser_ctl_port_chk.sv
module ser_ctl_port_chk #(
  parameter int DW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce_in,
  input logic          sclk_in,
  input logic          do_lo,
  input logic [DW-1:0] latch_a,
  input logic [DW-1:0] latch_b,
  input logic [DW-1:0] latch_c
);
  logic [2:0] cq, kq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cq <= '0;
      kq <= '0;
    end else begin
      cq <= {cq[1:0], ce_in};
      kq <= {kq[1:0], sclk_in};
    end
  end

  wire c_fall = ~cq[1] & cq[2];
  wire c_edge = cq[1] ^ cq[2];
  wire k_fall = ~kq[1] & kq[2];

  assert_commit_on_ce_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !c_fall |=> $stable({latch_a, latch_b, latch_c}));

  assert_single_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({latch_a != $past(latch_a), latch_b != $past(latch_b), latch_c != $past(latch_c)}));

  assert_do_open_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cq[1] && !cq[2]) |-> !do_lo);

  assert_do_moves_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(do_lo) |-> $past(k_fall || c_edge));
endmodule

bind ser_ctl_port ser_ctl_port_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_in(ce_in), .sclk_in(sclk_in), .do_lo(do_lo),
  .latch_a(latch_a), .latch_b(latch_b), .latch_c(latch_c)
);

// File: tb/tb_ser_ctl_port.sv
module tb_ser_ctl_port;
  logic clk = 0, rst_n = 0, ce = 0, sclk = 0, di = 0;
  logic do_lo;
  logic [23:0] la, lb, lc;
  logic [1:0]  st_port = 2'b10;
  logic        st_unlock = 1'b0;
  logic [19:0] st_count = 20'hA5C3E;
  logic        st_src = 1'b1;
  logic [23:0] ea = 0, eb = 0, ec = 0;
  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  ser_ctl_port dut (
    .clk(clk), .rst_n(rst_n), .ce_in(ce), .sclk_in(sclk), .di_in(di), .do_lo(do_lo),
    .latch_a(la), .latch_b(lb), .latch_c(lc),
    .st_port(st_port), .st_unlock(st_unlock), .st_count(st_count), .st_src(st_src)
  );

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(bit ok, string req, logic [71:0] act, logic [71:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic pulse(bit d);
    di = d; tick(2); sclk = 1; tick(4); sclk = 0; tick(2);
  endtask

  task automatic send_addr(logic [7:0] c);
    for (int i = 0; i < 4; i++) pulse(c[4+i]);
    for (int i = 0; i < 4; i++) pulse(c[i]);
  endtask

  task automatic write_xfer(logic [7:0] c, logic [23:0] d, int n, string req);
    ce = 0; tick(4);
    send_addr(c);
    ce = 1; tick(6);
    for (int i = 0; i < n; i++) pulse(i < 24 ? d[i] : ~d[i % 24]);
    tick(4);
    chk({la, lb, lc} == {ea, eb, ec}, {req, " R3 hold"}, {la, lb, lc}, {ea, eb, ec});
    chk(do_lo == 0, {req, " R10 open"}, 72'(do_lo), 72'd0);
    ce = 0; tick(8);
  endtask

  task automatic read_xfer(logic [23:0] w, int nbits, bit disturb, string req);
    ce = 0; tick(4);
    send_addr(8'hA2);
    ce = 1; tick(6);
    if (disturb) begin
      st_port = ~st_port; st_unlock = ~st_unlock; st_count = ~st_count; st_src = ~st_src;
    end
    for (int k = 0; k < nbits; k++) begin
      chk(do_lo == ~w[23-k], $sformatf("%s bit%0d", req, k), 72'(do_lo), 72'(~w[23-k]));
      sclk = 1; tick(4); sclk = 0; tick(6);
    end
    if (nbits == 24) begin
      pulse(0); pulse(0);
      chk(do_lo == 0, "R9 after 24", 72'(do_lo), 72'd0);
    end
    ce = 0; tick(8);
    chk(do_lo == 0, "R9/R10 released", 72'(do_lo), 72'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    tick(4); rst_n = 1; tick(4);
    chk({la, lb, lc} == 72'd0 && do_lo == 0, "R11 reset", {la, lb, lc}, 72'd0);

    // R1 R2 R5 R6: every code except the read code
    for (int c = 0; c < 256; c++) begin
      logic [23:0] d;
      if (c == 8'hA2) continue;
      d = {8'(c), ~8'(c), 8'(c) ^ 8'h5A};
      write_xfer(8'(c), d, 24, "R1/R6 sweep");
      if (c == 8'h82) ea = d;
      if (c == 8'h92) eb = d;
      if (c == 8'hB2) ec = d;
      chk({la, lb, lc} == {ea, eb, ec}, $sformatf("R1 R2 R6 code %02h", c), {la, lb, lc}, {ea, eb, ec});
    end

    // R4: short transfers discarded
    write_xfer(8'h82, 24'h123456, 23, "R4");
    chk(la == ea, "R4 short 23", 72'(la), 72'(ea));
    write_xfer(8'hB2, 24'hFFFFFF, 0, "R4");
    chk(lc == ec, "R4 short 0", 72'(lc), 72'(ec));

    // R5: overlong keeps first 24 bits, bit 0 first
    write_xfer(8'h92, 24'h800001, 30, "R5");
    eb = 24'h800001;
    chk(lb == eb, "R5 overlong", 72'(lb), 72'(eb));
    write_xfer(8'h82, 24'h000001, 24, "R5");
    ea = 24'h000001;
    chk(la == ea, "R5 lsb first", 72'(la), 72'(ea));

    // R7 R8 R9 reads
    read_xfer({2'b10, 1'b0, 20'hA5C3E, 1'b1}, 24, 1'b1, "R7 R8 read");
    read_xfer({2'b01, 1'b1, 20'h5A3C1, 1'b0}, 5, 1'b0, "R9 short read");
    read_xfer({2'b01, 1'b1, 20'h5A3C1, 1'b0}, 24, 1'b0, "R9 restart");
    chk({la, lb, lc} == {ea, eb, ec}, "R2 reads keep latches", {la, lb, lc}, {ea, eb, ec});

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule